// File: doc/BRIEF.md
# Tagged Multi-Line Receive Silo

This block collects received traffic from a group of eight serial lines into one shared first-in first-out store. Each stored word records three things: the character or status event, the line it came from, and the error conditions seen on it. The line receivers offer words on a per-line push port. Software drains the store by reading a receive-buffer port, and each read removes one word. A word whose top bit is clear means the store is empty, so software can drain it in a plain loop.

Line pushes wait in a one-word staging slot per line. The lowest-numbered occupied slot moves into the store on each cycle, so a push becomes readable after the second rising edge. The receive interrupt request has two causes. The first is an age timer, which counts millisecond ticks while the store holds data and restarts whenever the store runs empty. The second is a fill threshold at three quarters of the depth. A bit in the control/status word gates the request.

Top module: `mux_rx_silo`

## Requirements
- R1: A stored word has this layout: bit 15 valid (1), bit 14 overrun, bit 13 framing error, bit 12 parity error, bit 11 modem-status change, bits 10:8 source line, bits 7:0 character.
- R2: The receive-buffer port shows the oldest word, and a read strobe removes it. When the store is empty the port reads 0x0000 (bit 15 clear), and a read strobe changes nothing.
- R3: Words leave in the order they were stored, and the store holds up to DEPTH (default 64) words.
- R4: A push with the modem-change flag set stores bit 11 = 1 and the line number. Its character and error bits are 0, whatever the other inputs carry.
- R5: Pushes from several lines in one cycle are stored one per cycle, lowest line number first. A push offered before rising edge n is readable after edge n+1.
- R6: A staged word that finds no room is dropped. Room exists when the count, less any read in the same cycle, is below DEPTH. Bit 14 is then set on the next word that is stored, and only on that word.
- R7: The age counter counts tick pulses while the store is non-empty, saturates at its maximum, and is 0 whenever the store was empty at the previous edge. The request asserts while data is held and age >= timeout. A timeout of 0 asserts at once.
- R8: While the count is at least 3/4 of DEPTH (48 by default), the request asserts regardless of age.
- R9: The request is forced low unless the enable bit is 1. A control write loads the enable from bit 6 of the write data. The control/status read shows bit 7 = data available, bit 6 = enable, and all other bits 0.
- R10: After reset the store is empty, the buffer port reads 0x0000, the request is low, the enable is 0 and the timeout is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| ln_vld | input | 8 | Per-line push strobe |
| ln_char | input | 64 | Per-line character, line i at bits 8i+7:8i |
| ln_ferr | input | 8 | Per-line framing error flag |
| ln_perr | input | 8 | Per-line parity error flag |
| ln_mchg | input | 8 | Per-line flag marking the push as a modem-status change |
| rbuf_rd | input | 1 | Receive-buffer read strobe (pops one word) |
| rbuf_data | output | 16 | Oldest stored word, 0 when empty |
| csr_wr | input | 1 | Control write strobe |
| csr_wdata | input | 16 | Control write data, bit 6 = interrupt enable |
| csr_rdata | output | 16 | Control/status read value |
| tmo_wr | input | 1 | Timeout write strobe |
| tmo_wdata | input | TMO_W | New timeout in ticks |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume that a line never pushes while its own staging slot still holds an unstored word. This stays true as long as each line pushes no more often than once per eight cycles, which any real deserializer satisfies. The stimulus tracks the slot occupancy of the reference model and offers a push on a line only when that slot is free. It still produces bursts across lines in the same cycle, as well as fills past DEPTH to exercise the drop path. The tick input is assumed to be a single-cycle pulse, and the bench drives it that way.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int NLINES = 8;
    localparam int LID_W  = 3;
    localparam int CHAR_W = 8;

    // Word as seen by software; field order fixed by the read layout.
    typedef struct packed {
        logic              valid;
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic              mchg;
        logic [LID_W-1:0]  line;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    // Contents of one per-line staging slot.
    typedef struct packed {
        logic              mchg;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] data;
    } slot_t;
endpackage

// File: rtl/rxs_stage.sv
module rxs_stage
    import rxs_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NLINES-1:0]        in_vld,
    input  logic [NLINES*CHAR_W-1:0] in_char,
    input  logic [NLINES-1:0]        in_ferr,
    input  logic [NLINES-1:0]        in_perr,
    input  logic [NLINES-1:0]        in_mchg,
    output logic                     out_vld,
    output rx_entry_t                out_entry
);
    typedef struct packed {
        logic [NLINES-1:0]         occ;
        slot_t [NLINES-1:0]        slot;
    } stage_t;

    stage_t            s_d, s_q;
    slot_t [NLINES-1:0] incoming;
    logic [NLINES-1:0] take;
    logic [LID_W-1:0]  sel;
    logic              found;

    // Per-line formatting of an offered word; a status change carries no character.
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        assign incoming[g] = in_mchg[g]
            ? {1'b1, 1'b0, 1'b0, {CHAR_W{1'b0}}}
            : {1'b0, in_ferr[g], in_perr[g], in_char[g*CHAR_W +: CHAR_W]};

        AST_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld[g] |-> (!s_q.occ[g] || take[g])); // R5
    end

    always_comb begin
        s_d       = s_q;
        found     = 1'b0;
        sel       = '0;
        // Scan from the top so the lowest occupied line wins.
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (s_q.occ[i]) begin
                found = 1'b1;
                sel   = LID_W'(i);
            end
        end
        take      = found ? (NLINES'(1) << sel) : '0;
        out_vld   = found;
        out_entry.valid = 1'b1;
        out_entry.ovr   = 1'b0;
        out_entry.ferr  = s_q.slot[sel].ferr;
        out_entry.perr  = s_q.slot[sel].perr;
        out_entry.mchg  = s_q.slot[sel].mchg;
        out_entry.line  = sel;
        out_entry.data  = s_q.slot[sel].data;

        s_d.occ = s_q.occ & ~take;
        for (int i = 0; i < NLINES; i++) begin
            if (in_vld[i]) begin
                s_d.occ[i]  = 1'b1;
                s_d.slot[i] = incoming[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ((s_q.occ & ((NLINES'(1) << out_entry.line) - NLINES'(1))) == '0)); // R5

endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo
    import rxs_pkg::*;
#(
    parameter int DEPTH = 64,              // power of two
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_vld,
    input  rx_entry_t     wr_entry,
    input  logic          pop_req,
    output rx_entry_t     head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [CW-1:0]         cnt;
        logic                  ovr_pend;
    } fifo_t;

    fifo_t         s_d, s_q;
    logic          do_pop;
    logic          room;
    logic          store;
    logic [CW-1:0] cnt_left;
    rx_entry_t     wr_tagged;

    always_comb begin
        s_d       = s_q;
        do_pop    = pop_req && (s_q.cnt != '0);
        cnt_left  = s_q.cnt - CW'(do_pop);
        room      = (cnt_left < CW'(DEPTH));
        store     = wr_vld && room;
        wr_tagged = wr_entry;
        wr_tagged.ovr = s_q.ovr_pend;

        if (do_pop) s_d.rp = s_q.rp + AW'(1);
        if (store) begin
            s_d.mem[s_q.wp] = wr_tagged;
            s_d.wp          = s_q.wp + AW'(1);
            s_d.ovr_pend    = 1'b0;
        end else if (wr_vld) begin
            s_d.ovr_pend    = 1'b1;
        end
        s_d.cnt = cnt_left + CW'(store);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = (s_q.cnt != '0) ? s_q.mem[s_q.rp] : '0;
    assign count = s_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (s_q.cnt <= $past(s_q.cnt) + CW'(1))); // R3
    AST_DROP_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && !room) |=> s_q.ovr_pend); // R6

endmodule

// File: rtl/rxs_age.sv
module rxs_age #(
    parameter int TMO_W = 8,
    parameter int DEPTH = 64,
    localparam int CW     = $clog2(DEPTH) + 1,
    localparam int THRESH = (DEPTH * 3) / 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic [TMO_W-1:0] tmo,
    input  logic [CW-1:0]    cnt,
    output logic             irq
);
    typedef struct packed {
        logic [TMO_W-1:0] age;
    } age_t;

    age_t s_d, s_q;
    logic held;

    always_comb begin
        s_d  = s_q;
        held = (cnt != '0);
        if (!held)
            s_d.age = '0;
        else if (tick && (s_q.age != '1))
            s_d.age = s_q.age + TMO_W'(1);
        irq = enable && held && ((s_q.age >= tmo) || (cnt >= CW'(THRESH)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_AGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |=> (s_q.age == '0)); // R7
    AST_AGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (s_q.age <= $past(s_q.age))); // R7

endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
    import rxs_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int TMO_W = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ms_tick,
    input  logic [NLINES-1:0]        ln_vld,
    input  logic [NLINES*CHAR_W-1:0] ln_char,
    input  logic [NLINES-1:0]        ln_ferr,
    input  logic [NLINES-1:0]        ln_perr,
    input  logic [NLINES-1:0]        ln_mchg,
    input  logic                     rbuf_rd,
    output logic [15:0]              rbuf_data,
    input  logic                     csr_wr,
    input  logic [15:0]              csr_wdata,
    output logic [15:0]              csr_rdata,
    input  logic                     tmo_wr,
    input  logic [TMO_W-1:0]         tmo_wdata,
    output logic                     rx_irq
);
    localparam int RIE_BIT   = 6;
    localparam int AVAIL_BIT = 7;

    typedef struct packed {
        logic             rie;
        logic [TMO_W-1:0] tmo;
    } ctl_t;

    ctl_t          c_d, c_q;
    logic          stg_vld;
    rx_entry_t     stg_entry;
    rx_entry_t     head;
    logic [CW-1:0] fifo_cnt;
    logic          unused_wbits;

    assign unused_wbits = ^{csr_wdata[15:RIE_BIT+1], csr_wdata[RIE_BIT-1:0]};

    rxs_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (ln_vld),
        .in_char   (ln_char),
        .in_ferr   (ln_ferr),
        .in_perr   (ln_perr),
        .in_mchg   (ln_mchg),
        .out_vld   (stg_vld),
        .out_entry (stg_entry)
    );

    rxs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_vld   (stg_vld),
        .wr_entry (stg_entry),
        .pop_req  (rbuf_rd),
        .head     (head),
        .count    (fifo_cnt)
    );

    rxs_age #(.TMO_W(TMO_W), .DEPTH(DEPTH)) u_age (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (ms_tick),
        .enable (c_q.rie),
        .tmo    (c_q.tmo),
        .cnt    (fifo_cnt),
        .irq    (rx_irq)
    );

    always_comb begin
        c_d = c_q;
        if (csr_wr) c_d.rie = csr_wdata[RIE_BIT];
        if (tmo_wr) c_d.tmo = tmo_wdata;
        csr_rdata            = '0;
        csr_rdata[AVAIL_BIT] = (fifo_cnt != '0);
        csr_rdata[RIE_BIT]   = c_q.rie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.rie <= 1'b0;
            c_q.tmo <= TMO_W'(1);
        end else begin
            c_q <= c_d;
        end
    end

    assign rbuf_data = head;

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == '0) |-> !rbuf_data[15]); // R2
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.rie |-> !rx_irq); // R9

endmodule

// File: tb/sim_mux_rx_silo.sv
`timescale 1ns/1ps
module sim_mux_rx_silo;
    localparam int DEPTH = 64;
    localparam int TMO_W = 8;
    localparam int NL    = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ms_tick;
    logic [NL-1:0] ln_vld, ln_ferr, ln_perr, ln_mchg;
    logic [NL*8-1:0] ln_char;
    logic          rbuf_rd;
    logic [15:0]   rbuf_data;
    logic          csr_wr;
    logic [15:0]   csr_wdata;
    logic [15:0]   csr_rdata;
    logic          tmo_wr;
    logic [TMO_W-1:0] tmo_wdata;
    logic          rx_irq;

    always #2.5 clk = ~clk;

    mux_rx_silo #(.DEPTH(DEPTH), .TMO_W(TMO_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .ln_vld(ln_vld), .ln_char(ln_char), .ln_ferr(ln_ferr),
        .ln_perr(ln_perr), .ln_mchg(ln_mchg),
        .rbuf_rd(rbuf_rd), .rbuf_data(rbuf_data),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .tmo_wr(tmo_wr), .tmo_wdata(tmo_wdata), .rx_irq(rx_irq)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] mq[$];
    bit          mocc[NL];
    logic [10:0] mslot[NL];   // {mchg, ferr, perr, char}
    bit          mpend;
    int          mage;
    bit          mrie;
    int          mtmo;

    function automatic logic [15:0] exp_rd();
        return (mq.size() > 0) ? mq[0] : 16'h0000;
    endfunction
    function automatic logic exp_irq();
        return mrie && (mq.size() > 0) && ((mage >= mtmo) || (mq.size() >= 48));
    endfunction
    function automatic logic [15:0] exp_csr();
        return {8'h00, (mq.size() > 0) ? 1'b1 : 1'b0, mrie ? 1'b1 : 1'b0, 6'b0};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        int osz;
        int dr;
        logic [15:0] e;
        if (!rst_n) begin
            mq.delete();
            for (int i = 0; i < NL; i++) mocc[i] = 0;
            mpend = 0; mage = 0; mrie = 0; mtmo = 1;
        end else begin
            osz = mq.size();
            dr  = -1;
            e   = 16'h0;
            for (int i = NL - 1; i >= 0; i--) if (mocc[i]) dr = i;
            if (dr >= 0) begin
                e = {1'b1, 1'b0, mslot[dr][9], mslot[dr][8], mslot[dr][10], 3'(dr), mslot[dr][7:0]};
                mocc[dr] = 0;
            end
            for (int i = 0; i < NL; i++) begin
                if (ln_vld[i]) begin
                    mocc[i]  = 1;
                    mslot[i] = ln_mchg[i] ? 11'h400 : {1'b0, ln_ferr[i], ln_perr[i], ln_char[i*8 +: 8]};
                end
            end
            if (rbuf_rd && osz > 0) void'(mq.pop_front());
            if (dr >= 0) begin
                if (mq.size() < DEPTH) begin
                    e[14] = mpend;
                    mpend = 0;
                    mq.push_back(e);
                end else begin
                    mpend = 1;
                end
            end
            if (osz == 0) mage = 0;
            else if (ms_tick && mage < 255) mage++;
            if (csr_wr) mrie = csr_wdata[6];
            if (tmo_wr) mtmo = int'(tmo_wdata);
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 R3 rbuf_data vs model", rbuf_data, exp_rd());
            chk("R7 R8 rx_irq vs model", rx_irq, exp_irq());
            chk("R9 csr_rdata vs model", csr_rdata, exp_csr());
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL R3 watchdog actual=%0d cycles expected=completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle();
        ln_vld = '0; ln_ferr = '0; ln_perr = '0; ln_mchg = '0; ln_char = '0;
        rbuf_rd = 0; csr_wr = 0; csr_wdata = '0; tmo_wr = 0; tmo_wdata = '0; ms_tick = 0;
    endtask

    task automatic drive(input int l, input logic [7:0] d, input logic fe, input logic pe, input logic mc);
        ln_vld[l] = 1'b1; ln_char[l*8 +: 8] = d;
        ln_ferr[l] = fe; ln_perr[l] = pe; ln_mchg[l] = mc;
    endtask

    // Push one word and return once it is readable (two edges).
    task automatic push1(input int l, input logic [7:0] d);
        drive(l, d, 1'b0, 1'b0, 1'b0);
        @(negedge clk); idle();
        @(negedge clk);
    endtask

    task automatic pop1();
        rbuf_rd = 1'b1;
        @(negedge clk); idle();
    endtask

    task automatic tick1();
        ms_tick = 1'b1;
        @(negedge clk); idle();
    endtask

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset rbuf_data", rbuf_data, 16'h0000);
        chk("R10 reset rx_irq", rx_irq, 0);
        chk("R10 reset csr_rdata", csr_rdata, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: parity error char on line 3
        drive(3, 8'hA5, 1'b0, 1'b1, 1'b0);
        @(negedge clk); idle();
        chk("R5 not visible after one edge", rbuf_data, 16'h0000);
        @(negedge clk);
        chk("R1 entry layout", rbuf_data, 16'h93A5);
        pop1();
        chk("R2 empty after pop", rbuf_data, 16'h0000);
        pop1();
        chk("R2 empty read leaves zero", rbuf_data, 16'h0000);

        // R5: three lines in one cycle
        drive(7, 8'h11, 1'b0, 1'b0, 1'b0);
        drive(5, 8'h22, 1'b1, 1'b0, 1'b0);
        drive(2, 8'h33, 1'b0, 1'b0, 1'b0);
        @(negedge clk); idle();
        @(negedge clk);
        chk("R5 lowest line first", rbuf_data, 16'h8233);
        rbuf_rd = 1'b1;
        @(negedge clk);
        chk("R5 second line", rbuf_data, 16'hA522);
        @(negedge clk);
        chk("R5 third line", rbuf_data, 16'h8711);
        @(negedge clk); idle();
        chk("R3 drained", rbuf_data, 16'h0000);

        // R4: modem-status change ignores char and flags
        drive(6, 8'hFF, 1'b1, 1'b1, 1'b1);
        @(negedge clk); idle();
        @(negedge clk);
        chk("R4 modem change word", rbuf_data, 16'h8E00);
        pop1();

        // R10 default timeout 1, R7 age timer
        csr_wr = 1'b1; csr_wdata = 16'h0040;
        @(negedge clk); idle();
        push1(1, 8'h5A);
        chk("R10 irq before tick", rx_irq, 0);
        tick1();
        chk("R10 default timeout is one tick", rx_irq, 1);
        pop1();
        chk("R7 irq drops when empty", rx_irq, 0);
        tmo_wr = 1'b1; tmo_wdata = 8'd3;
        @(negedge clk); idle();
        push1(1, 8'h5B);
        tick1(); tick1();
        chk("R7 two ticks below timeout", rx_irq, 0);
        tick1();
        chk("R7 timeout reached", rx_irq, 1);
        pop1();
        @(negedge clk);
        push1(2, 8'h5C);
        tick1(); tick1();
        chk("R7 age restarted after empty", rx_irq, 0);
        pop1();

        // R8 threshold, R6 overflow
        tmo_wr = 1'b1; tmo_wdata = 8'd200;
        @(negedge clk); idle();
        for (int k = 0; k < 47; k++) push1(k % 8, 8'(k));
        chk("R8 below threshold", rx_irq, 0);
        push1(47 % 8, 8'd47);
        chk("R8 at threshold", rx_irq, 1);
        for (int k = 48; k < 64; k++) push1(k % 8, 8'(k));
        push1(0, 8'hE0);
        push1(1, 8'hE1);
        chk("R6 full head intact", rbuf_data, 16'h8000);
        pop1();
        push1(4, 8'h77);
        for (int k = 1; k < 64; k++) begin
            chk("R3 order after fill", rbuf_data, 16'h8000 | 16'((k % 8) << 8) | 16'(k));
            rbuf_rd = 1'b1;
            @(negedge clk);
        end
        idle();
        chk("R6 overrun tag on next stored", rbuf_data, 16'hC477);
        pop1();
        push1(0, 8'h01);
        chk("R6 overrun tag only once", rbuf_data, 16'h8001);

        // R9 gating and status read
        csr_wr = 1'b1; csr_wdata = 16'hFFBF;
        @(negedge clk); idle();
        chk("R9 csr shows data, enable off", csr_rdata, 16'h0080);
        tmo_wr = 1'b1; tmo_wdata = 8'd0;
        @(negedge clk); idle();
        chk("R9 irq gated off", rx_irq, 0);
        csr_wr = 1'b1; csr_wdata = 16'h0040;
        @(negedge clk); idle();
        chk("R9 csr enable on", csr_rdata, 16'h00C0);
        chk("R7 zero timeout immediate", rx_irq, 1);
        pop1();

        // Mixed traffic compared cycle by cycle against the model
        for (int c = 0; c < 6000; c++) begin
            for (int i = 0; i < NL; i++) begin
                if (!mocc[i] && ($urandom % 5 == 0))
                    drive(i, 8'($urandom), 1'($urandom), 1'($urandom), ($urandom % 7 == 0));
            end
            rbuf_rd = ((c / 700) % 2 == 0) ? ($urandom % 8 == 0) : ($urandom % 2 == 0);
            ms_tick = ($urandom % 9 == 0);
            if ($urandom % 300 == 0) begin tmo_wr = 1'b1; tmo_wdata = 8'($urandom % 12); end
            if ($urandom % 400 == 0) begin csr_wr = 1'b1; csr_wdata = 16'($urandom); end
            @(negedge clk); idle();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule